// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers completion events from a bank of DMA channels into one interrupt line. Every channel raises two kinds of single-cycle event: a half-way mark and a final completion. Each event sets its own sticky flag in a status word. A mask word, writable by software, selects which flags may drive the interrupt line. Software reads the status word to find the cause. It then acknowledges events by writing ones to the status word. Any bit written as zero is left unchanged.

Both words sit on a small synchronous register bus with a one-cycle read latency. The channels are interleaved across the status word. Channel n owns bit 2n for its half-way event and bit 2n+1 for its completion event. With the default sixteen channels this fills all 32 bits. The upper half of the channel indices (8 to 15) is reserved for the dedicated class of channels and the lower half for the normal class. The split affects naming only, not behaviour.

A small register-bus state machine handles accesses. It has three states:
- IDLE waits for a request.
- READ_RESP presents read data for one cycle.
- WRITE_ACK acknowledges a write for one cycle.

The transitions are:
- IDLE to READ_RESP when a read request arrives.
- IDLE to WRITE_ACK when a write request arrives.
- READ_RESP to IDLE.
- WRITE_ACK to IDLE.

Top module: `dma_irq_aggr`

## Requirements
- R1: After reset the mask word (offset 0x0) and the status word (offset 0x4) both read zero, and `irq_o` is low.
- R2: An event pulse on `half_evt_i[n]` sets status bit 2n, and an event pulse on `end_evt_i[n]` sets status bit 2n+1. Each bit is set on the clock edge where its pulse is sampled and stays set until it is cleared.
- R3: A status bit sets on its event even when the matching mask bit is zero.
- R4: A write to offset 0x4 clears exactly the status bits written as one. Bits written as zero keep their value, and writing 0xFFFFFFFF clears every bit.
- R5: If an event and a write-one-to-clear hit the same bit in the same cycle, the bit stays set.
- R6: A write to offset 0x0 replaces the mask word with the written value.
- R7: `irq_o` is a register. It is high on the cycle after any bit of (status AND mask) is one, and low on the cycle after none is.
- R8: A read returns the register contents in `rdata_o`, with `rvalid_o` high on the cycle after the request. Reading has no side effects, so two consecutive reads with no events in between return the same status. A read of any other offset returns zero.
- R9: Every request is answered exactly one cycle later: `rvalid_o` answers a read and `wack_o` answers a write. While a request is being answered, `req_i` is ignored, so requests must be spaced at least two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |
| wack_o | output | 1 | Write acknowledge |
| half_evt_i | input | 16 | Half-way event pulses, one per channel |
| end_evt_i | input | 16 | Completion event pulses, one per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: sixteen channels, a 32-bit data word and an 8-bit offset. With these values the status word is exactly full, so the top channel's completion event lands on bit 31. The same build exercises a write of 0xFFFFFFFF against all flags at once, and covers channels on both sides of the normal/dedicated split. Same-cycle collisions between an event and a clear are driven on purpose, and the interrupt output is sampled one cycle after every mask or status change.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    typedef enum logic [1:0] {
        BUS_IDLE      = 2'd0,
        BUS_READ_RESP = 2'd1,
        BUS_WRITE_ACK = 2'd2
    } bus_state_e;
endpackage

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
    parameter int NCH = 16,
    localparam int W = 2 * NCH
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NCH-1:0] half_evt_i,
    input  logic [NCH-1:0] end_evt_i,
    input  logic           clr_en_i,
    input  logic [W-1:0]   clr_mask_i,
    output logic [W-1:0]   flags_o
);
    logic [W-1:0] evt_vec;

    // Interleave: channel n -> bits 2n (half) and 2n+1 (end)
    for (genvar n = 0; n < NCH; n++) begin : g_map
        assign evt_vec[2*n]   = half_evt_i[n];
        assign evt_vec[2*n+1] = end_evt_i[n];
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk_i) begin
            if (!rst_ni)
                flags_o[b] <= 1'b0;
            else if (evt_vec[b])
                flags_o[b] <= 1'b1;
            else if (clr_en_i && clr_mask_i[b])
                flags_o[b] <= 1'b0;
        end
    end

    // R5: event in a collision keeps the bit set
    p_evt_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_vec[0] && clr_en_i && clr_mask_i[0]) |=> flags_o[0]);
    // R2: a set flag without a clear stays set
    p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_o[W-1] && !clr_en_i) |=> flags_o[W-1]);
endmodule

// File: rtl/dma_irq_bus.sv
module dma_irq_bus #(
    parameter int DW = 32,
    parameter int AW = 8,
    parameter logic [AW-1:0] MASK_OFS = 8'h00,
    parameter logic [AW-1:0] STAT_OFS = 8'h04
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] mask_i,
    input  logic [DW-1:0] flags_i,
    output logic          mask_we_o,
    output logic          clr_en_o,
    output logic [DW-1:0] wdata_o,
    output logic [DW-1:0] rdata_o,
    output logic          rvalid_o,
    output logic          wack_o
);
    import dma_irq_pkg::*;

    bus_state_e state_q, state_d;
    logic [DW-1:0] rdata_q;
    logic accept;

    // Requests are taken only in IDLE
    assign accept    = req_i && (state_q == BUS_IDLE);
    assign mask_we_o = accept && we_i && (addr_i == MASK_OFS);
    assign clr_en_o  = accept && we_i && (addr_i == STAT_OFS);
    assign wdata_o   = wdata_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:      if (req_i) state_d = we_i ? BUS_WRITE_ACK : BUS_READ_RESP;
            BUS_READ_RESP: state_d = BUS_IDLE;
            BUS_WRITE_ACK: state_d = BUS_IDLE;
            default:       state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= BUS_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            rdata_q <= '0;
        else if (accept && !we_i)
            rdata_q <= (addr_i == MASK_OFS) ? mask_i :
                       (addr_i == STAT_OFS) ? flags_i : '0;
    end

    always_comb begin
        rvalid_o = (state_q == BUS_READ_RESP);
        wack_o   = (state_q == BUS_WRITE_ACK);
        rdata_o  = rvalid_o ? rdata_q : '0;
    end

    // R9: one response per request, the cycle after
    p_read_resp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && !we_i) |=> rvalid_o);
    p_write_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && we_i) |=> wack_o);
    p_onehot_resp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rvalid_o, wack_o}));
endmodule

// File: rtl/dma_irq_aggr.sv
module dma_irq_aggr #(
    parameter int NCH = 16,
    parameter int AW  = 8,
    localparam int DW = 2 * NCH
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           req_i,
    input  logic           we_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [DW-1:0]  wdata_i,
    output logic [DW-1:0]  rdata_o,
    output logic           rvalid_o,
    output logic           wack_o,
    input  logic [NCH-1:0] half_evt_i,
    input  logic [NCH-1:0] end_evt_i,
    output logic           irq_o
);
    logic [DW-1:0] mask_q, flags, wdata;
    logic mask_we, clr_en;

    dma_irq_bus #(.DW(DW), .AW(AW)) u_bus (
        .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .mask_i(mask_q), .flags_i(flags),
        .mask_we_o(mask_we), .clr_en_o(clr_en), .wdata_o(wdata),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o), .wack_o(wack_o)
    );

    dma_irq_flags #(.NCH(NCH)) u_flags (
        .clk_i(clk_i), .rst_ni(rst_ni), .half_evt_i(half_evt_i),
        .end_evt_i(end_evt_i), .clr_en_i(clr_en), .clr_mask_i(wdata),
        .flags_o(flags)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni)      mask_q <= '0;
        else if (mask_we) mask_q <= wdata;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) irq_o <= 1'b0;
        else         irq_o <= |(flags & mask_q);
    end

    // R7: the line follows the masked flags one cycle later
    p_irq_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(flags & mask_q)) |=> irq_o);
    p_irq_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags == '0) |=> !irq_o);
    // R6: the mask holds unless it is written
    p_mask_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mask_we |=> $stable(mask_q));
endmodule

// File: tb/dma_irq_aggr_tb.sv
module dma_irq_aggr_tb;
    logic clk = 0, rst_n = 0, req = 0, we = 0;
    logic [7:0] addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic rvalid, wack, irq;
    logic [15:0] hevt = 0, eevt = 0;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    dma_irq_aggr u_dut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .wack_o(wack),
        .half_evt_i(hevt), .end_evt_i(eevt), .irq_o(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
        @(negedge clk); req = 0; we = 0;
        chk("R9 wack", {31'b0, wack}, 1);
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); req = 1; we = 0; addr = a;
        @(negedge clk); req = 0;
        chk("R9 rvalid", {31'b0, rvalid}, 1);
        d = rdata;
    endtask

    task automatic pulse(logic [15:0] h, logic [15:0] e);
        @(negedge clk); hevt = h; eevt = e;
        @(negedge clk); hevt = 0; eevt = 0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h00, d); chk("R1 mask", d, 0);
        rd(8'h04, d); chk("R1 status", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_set_masked;
        logic [31:0] d;
        pulse(16'h0001, 16'h8000);
        rd(8'h04, d); chk("R2 R3 set bits 0,31", d, 32'h8000_0001);
        chk("R3 irq masked", {31'b0, irq}, 0);
        pulse(16'h0100, 16'h0100);
        rd(8'h04, d); chk("R2 ch8 bits 16,17", d, 32'h8003_0001);
        rd(8'h04, d); chk("R8 no side effect", d, 32'h8003_0001);
        rd(8'h10, d); chk("R8 unmapped", d, 0);
    endtask

    task automatic t_mask_irq;
        logic [31:0] d;
        wr(8'h00, 32'h0002_0000);
        rd(8'h00, d); chk("R6 mask", d, 32'h0002_0000);
        chk("R7 irq high", {31'b0, irq}, 1);
        wr(8'h04, 32'h0002_0000);
        @(negedge clk);
        chk("R7 irq low", {31'b0, irq}, 0);
        rd(8'h04, d); chk("R4 partial clear", d, 32'h8001_0001);
    endtask

    task automatic t_collision;
        logic [31:0] d;
        @(negedge clk); req = 1; we = 1; addr = 8'h04; wdata = 32'h0000_0003; hevt = 16'h0001;
        @(negedge clk); req = 0; we = 0; hevt = 0;
        rd(8'h04, d); chk("R5 event wins", d, 32'h8001_0001);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, d); chk("R4 clear all", d, 0);
    endtask

    initial begin
        fork
            begin : wd
                repeat (5000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected done");
            end
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                t_reset();
                t_set_masked();
                t_mask_irq();
                t_collision();
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule